// File: doc/BRIEF.md
# Raster Word and Line Counter

This block tracks where a monochrome bitmap display is in its raster. It holds two counters. One counts word slots across a line. The other counts lines across a frame. Both advance only when the video-counter strobe is high. From the counter values the block produces the current slot and line numbers as video address fields. It also produces blanking flags for each axis, a display-enable flag, a flag for the one sound slot per line, and horizontal and vertical sync pulses.

Neither counter starts its useful range at zero. Each line has 44 slots. Slots 0x00 to 0x1F carry picture data. Slots 0x20 to 0x2A are horizontal retrace, and the last slot, 0x2B, is given to sound. The 9-bit line counter runs from 0x080 to 0x1F1. The first 28 values, 0x080 to 0x09B, are vertical retrace, and lines 0x09C to 0x1F1 are visible. All flags are registered and are updated on the same edge as the counters, so in any cycle the flags describe the counter values shown in that cycle.

Top module: `raster_scan_counter`

## Requirements
- R1: A synchronous active-high reset sets h_slot to 0x00 and v_line to 0x080. After reset, hblank=0, vblank=1, disp_en=0, snd_slot=0, hsync=0 and vsync=1.
- R2: The counters change only on a clock edge where strobe is 1. When strobe is 0, every output keeps its value.
- R3: Each strobe moves h_slot up by one. A strobe at slot 0x2B returns h_slot to 0x00, so one line lasts 44 strobes.
- R4: v_line moves up by one only on a strobe that wraps h_slot. A wrap at line 0x1F1 returns v_line to 0x080, so one frame lasts 370 lines, which is 16280 strobes.
- R5: hblank is 1 exactly when h_slot is in the range 0x20 to 0x2B.
- R6: vblank is 1 exactly when v_line is in the range 0x080 to 0x09B.
- R7: disp_en is 1 exactly when hblank and vblank are both 0.
- R8: snd_slot is 1 exactly when h_slot is 0x2B, on every line, including the lines of vertical retrace.
- R9: hsync is 1 exactly when h_slot is in the range 0x22 to 0x27.
- R10: vsync is 1 exactly when v_line is in the range 0x080 to 0x082.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Video-counter advance pulse |
| h_slot | output | 6 | Current word slot within the line |
| v_line | output | 9 | Current line within the frame |
| hblank | output | 1 | High in horizontal retrace and in the sound slot |
| vblank | output | 1 | High in vertical retrace |
| disp_en | output | 1 | High when a visible word is being addressed |
| snd_slot | output | 1 | High in the per-line sound slot |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |

## Verification
The assertions check the stepping rules on every cycle. They check that a counter holds when there is no strobe, that each strobe moves h_slot up by one, and that both wrap points go to the right values. They also check that h_slot stays in range, that the sound flag falls inside horizontal blanking, and that display enable never overlaps a blank flag. Only the bench's sweeps can show that each flag changes at exactly the right slot or line value. The same holds for the length of a full frame, that reset brings the block back to its start state from the middle of a frame, and that idle cycles between strobes have no effect.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef struct packed {
    logic hblank;
    logic vblank;
    logic disp_en;
    logic snd_slot;
    logic hsync;
    logic vsync;
  } raster_flags_t;
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int HW     = 6,
  parameter int H_LAST = 43
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [HW-1:0] h_q,
  output logic [HW-1:0] h_d,
  output logic          wrap
);
  localparam logic [HW-1:0] LAST_C = HW'(H_LAST);

  always_comb begin
    wrap = adv && (h_q == LAST_C);
    if (rst)       h_d = '0;
    else if (wrap) h_d = '0;
    else if (adv)  h_d = h_q + 1'b1;
    else           h_d = h_q;
  end

  always_ff @(posedge clk) h_q <= h_d;
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int VW      = 9,
  parameter int V_FIRST = 128,
  parameter int V_LAST  = 497
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [VW-1:0] v_q,
  output logic [VW-1:0] v_d
);
  localparam logic [VW-1:0] FIRST_C = VW'(V_FIRST);
  localparam logic [VW-1:0] LAST_C  = VW'(V_LAST);

  always_comb begin
    if (rst)                      v_d = FIRST_C;
    else if (adv && v_q == LAST_C) v_d = FIRST_C;
    else if (adv)                 v_d = v_q + 1'b1;
    else                          v_d = v_q;
  end

  always_ff @(posedge clk) v_q <= v_d;
endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int HW          = 6,
  parameter int VW          = 9,
  parameter int H_ACTIVE    = 32,
  parameter int H_LAST      = 43,
  parameter int HSYNC_FIRST = 34,
  parameter int HSYNC_LAST  = 39,
  parameter int V_FIRST     = 128,
  parameter int V_RETRACE   = 28,
  parameter int VSYNC_LINES = 3
) (
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  output raster_flags_t flags
);
  localparam logic [HW-1:0] H_ACT_END_C = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_LAST_C    = HW'(H_LAST);
  localparam logic [HW-1:0] HS_FIRST_C  = HW'(HSYNC_FIRST);
  localparam logic [HW-1:0] HS_LAST_C   = HW'(HSYNC_LAST);
  localparam logic [VW-1:0] V_ACT_C     = VW'(V_FIRST + V_RETRACE);
  localparam logic [VW-1:0] VS_END_C    = VW'(V_FIRST + VSYNC_LINES);

  always_comb begin
    flags.hblank   = (h >= H_ACT_END_C);
    flags.vblank   = (v < V_ACT_C);
    flags.disp_en  = !flags.hblank && !flags.vblank;
    flags.snd_slot = (h == H_LAST_C);
    flags.hsync    = (h >= HS_FIRST_C) && (h <= HS_LAST_C);
    flags.vsync    = (v < VS_END_C);
  end
endmodule

// File: rtl/raster_scan_counter.sv
module raster_scan_counter
  import raster_pkg::*;
#(
  parameter int H_ACTIVE    = 32,
  parameter int H_RETRACE   = 11,
  parameter int HSYNC_FIRST = 34,
  parameter int HSYNC_LAST  = 39,
  parameter int VW          = 9,
  parameter int V_FIRST     = 128,
  parameter int V_RETRACE   = 28,
  parameter int V_LAST      = 497,
  parameter int VSYNC_LINES = 3,
  localparam int H_TOTAL    = H_ACTIVE + H_RETRACE + 1,
  localparam int HW         = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  output logic [HW-1:0] h_slot,
  output logic [VW-1:0] v_line,
  output logic          hblank,
  output logic          vblank,
  output logic          disp_en,
  output logic          snd_slot,
  output logic          hsync,
  output logic          vsync
);
  localparam int H_LAST = H_TOTAL - 1;

  logic [HW-1:0] h_d;
  logic [VW-1:0] v_d;
  logic          h_wrap;
  raster_flags_t flags_d, flags_q;

  raster_hcount #(.HW(HW), .H_LAST(H_LAST)) u_h (
    .clk(clk), .rst(rst), .adv(strobe),
    .h_q(h_slot), .h_d(h_d), .wrap(h_wrap)
  );

  raster_vcount #(.VW(VW), .V_FIRST(V_FIRST), .V_LAST(V_LAST)) u_v (
    .clk(clk), .rst(rst), .adv(h_wrap),
    .v_q(v_line), .v_d(v_d)
  );

  raster_decode #(
    .HW(HW), .VW(VW), .H_ACTIVE(H_ACTIVE), .H_LAST(H_LAST),
    .HSYNC_FIRST(HSYNC_FIRST), .HSYNC_LAST(HSYNC_LAST),
    .V_FIRST(V_FIRST), .V_RETRACE(V_RETRACE), .VSYNC_LINES(VSYNC_LINES)
  ) u_dec (
    .h(h_d), .v(v_d), .flags(flags_d)
  );

  // Flags are decoded from the next counter values, so they line up with the counters.
  always_ff @(posedge clk) flags_q <= flags_d;

  assign hblank   = flags_q.hblank;
  assign vblank   = flags_q.vblank;
  assign disp_en  = flags_q.disp_en;
  assign snd_slot = flags_q.snd_slot;
  assign hsync    = flags_q.hsync;
  assign vsync    = flags_q.vsync;
endmodule

// File: rtl/raster_scan_counter_chk.sv
module raster_scan_counter_chk #(
  parameter int HW      = 6,
  parameter int VW      = 9,
  parameter int H_LAST  = 43,
  parameter int V_FIRST = 128,
  parameter int V_LAST  = 497
) (
  input logic          clk,
  input logic          rst,
  input logic          strobe,
  input logic [HW-1:0] h_slot,
  input logic [VW-1:0] v_line,
  input logic          hblank,
  input logic          vblank,
  input logic          disp_en,
  input logic          snd_slot
);
  localparam logic [HW-1:0] H_LAST_C  = HW'(H_LAST);
  localparam logic [VW-1:0] V_FIRST_C = VW'(V_FIRST);
  localparam logic [VW-1:0] V_LAST_C  = VW'(V_LAST);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(h_slot) && $stable(v_line)));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (strobe && h_slot != H_LAST_C) |=> (h_slot == HW'($past(h_slot) + 1'b1)));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (strobe && h_slot == H_LAST_C) |=> (h_slot == '0));

  a_r3_range: assert property (@(posedge clk) disable iff (rst)
    h_slot <= H_LAST_C);

  a_r4_line_step: assert property (@(posedge clk) disable iff (rst)
    (strobe && h_slot == H_LAST_C && v_line != V_LAST_C)
      |=> (v_line == VW'($past(v_line) + 1'b1)));

  a_r4_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (strobe && h_slot == H_LAST_C && v_line == V_LAST_C) |=> (v_line == V_FIRST_C));

  a_r4_line_hold: assert property (@(posedge clk) disable iff (rst)
    (h_slot != H_LAST_C) |=> $stable(v_line));

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> (!hblank && !vblank));

  a_r8_in_blank: assert property (@(posedge clk) disable iff (rst)
    snd_slot |-> (hblank && h_slot == H_LAST_C));
endmodule

bind raster_scan_counter raster_scan_counter_chk #(
  .HW(HW), .VW(VW), .H_LAST(H_LAST), .V_FIRST(V_FIRST), .V_LAST(V_LAST)
) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .h_slot(h_slot), .v_line(v_line),
  .hblank(hblank), .vblank(vblank), .disp_en(disp_en), .snd_slot(snd_slot)
);

// File: tb/raster_scan_counter_tb.sv
module raster_scan_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic [5:0] h_slot;
  logic [8:0] v_line;
  logic       hblank, vblank, disp_en, snd_slot, hsync, vsync;

  int tests = 0;
  int fails = 0;
  int eh = 0;
  int ev = 128;
  int strobes = 0;
  bit done = 0;

  always #10 clk = ~clk;

  raster_scan_counter u_dut (
    .clk(clk), .rst(rst), .strobe(strobe), .h_slot(h_slot), .v_line(v_line),
    .hblank(hblank), .vblank(vblank), .disp_en(disp_en), .snd_slot(snd_slot),
    .hsync(hsync), .vsync(vsync)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s h=%0d v=%0d actual=%0d expected=%0d", req, eh, ev, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    int hb, vb;
    hb = (eh >= 32) ? 1 : 0;
    vb = (ev < 156) ? 1 : 0;
    chk({"R3 h_slot ", ctx}, int'(h_slot), eh);
    chk({"R4 v_line ", ctx}, int'(v_line), ev);
    chk({"R5 hblank ", ctx}, int'(hblank), hb);
    chk({"R6 vblank ", ctx}, int'(vblank), vb);
    chk({"R7 disp_en ", ctx}, int'(disp_en), (hb == 0 && vb == 0) ? 1 : 0);
    chk({"R8 snd_slot ", ctx}, int'(snd_slot), (eh == 43) ? 1 : 0);
    chk({"R9 hsync ", ctx}, int'(hsync), (eh >= 34 && eh <= 39) ? 1 : 0);
    chk({"R10 vsync ", ctx}, int'(vsync), (ev <= 130) ? 1 : 0);
  endtask

  // Applies one cycle with the given strobe value; the checks run at the following negedge.
  task automatic cycle(input logic s);
    strobe = s;
    @(negedge clk);
    strobe = 1'b0;
    if (s) begin
      strobes++;
      if (eh == 43) begin
        eh = 0;
        ev = (ev == 497) ? 128 : ev + 1;
      end else begin
        eh = eh + 1;
      end
    end
    check_all(s ? "strobe" : "R2 idle");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    eh = 0;
    ev = 128;
    check_all("R1 reset");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset values in explicit form
    chk("R1 h_slot reset", int'(h_slot), 0);
    chk("R1 v_line reset", int'(v_line), 128);
    chk("R1 vblank reset", int'(vblank), 1);
    chk("R1 vsync reset", int'(vsync), 1);

    // One full frame with idle cycles sprinkled between strobes (R2..R10).
    strobes = 0;
    for (int i = 0; i < 16280; i++) begin
      cycle(1'b1);
      if (i % 7 == 3) cycle(1'b0);
      if (i % 97 == 50) begin
        cycle(1'b0);
        cycle(1'b0);
      end
    end
    // R4: a frame of 16280 strobes returns to the start position.
    chk("R4 frame strobes", strobes, 16280);
    chk("R4 frame wrap h_slot", int'(h_slot), 0);
    chk("R4 frame wrap v_line", int'(v_line), 128);

    // Continue into the second frame past the first visible line.
    for (int i = 0; i < 44 * 30 + 5; i++) cycle(1'b1);
    chk("R6 visible line reached", int'(v_line), 158);

    // R1: reset from the middle of a frame.
    do_reset();
    chk("R1 mid-frame h_slot", int'(h_slot), 0);
    chk("R1 mid-frame v_line", int'(v_line), 128);
    for (int i = 0; i < 100; i++) cycle(1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule